// File: doc/BRIEF.md
# Alpha Multiplier with Interleaved Segment Parity

This block multiplies an element of the binary extension field GF(2^M) by the field root alpha and reduces the result by a fixed field polynomial. The polynomial is a parameter; its leading term x^M is implied. Alongside the product it predicts a K-bit parity vector for the result, working only from the caller's K-bit parity vector of the operand and the operand's top bit. It serves as the per-round stage of a fault-detecting serial multiplier, where parity travels with the data from stage to stage.

The parity split is interleaved. Parity bit j covers every operand bit whose index modulo K equals j, so it covers bits j, K+j, 2K+j and so on. With this split, a left shift by one position moves whole segments into the next segment. Each predicted bit is therefore one neighbouring input parity bit, flipped by the operand's top bit only where the polynomial's segment parity requires it. That costs at most one XOR per segment.

An optional local checker regenerates the interleaved parity of the computed product and raises an error flag on any disagreement with the prediction. Inputs are sampled on each rising clock edge, and all outputs are registered, so results appear one cycle later. Elaboration stops if K does not divide M.

Top module: `alpha_mul_ilp`

## Requirements
- R1: One cycle after an operand is applied, `prod_q` equals the operand shifted left by one bit with bit 0 cleared. When the operand's bit M-1 is 1, the shifted value is also XORed with the M low coefficients of the field polynomial (parameter `POLY`, bit i = coefficient of x^i).
- R2: For every segment index j from 1 to K-1, `par_q[j]` equals the XOR of `par_in[j-1]` and (`a_in[M-1]` AND the XOR of `POLY` bits j, K+j, 2K+j, ...). When `par_in` is the true interleaved parity of `a_in`, this equals the interleaved parity of `prod_q` for segment j.
- R3: `par_q[0]` equals the XOR of `par_in[K-1]` and (`a_in[M-1]` AND NOT the XOR of `POLY` bits 0, K, 2K, ...). With consistent input parity, this equals the XOR of `prod_q` bits 0, K, 2K, ....
- R4: When `a_in[M-1]` is 0, the product is a pure left shift, and `par_q` is `par_in` rotated up by one position (`par_q[j] = par_in[j-1]`, `par_q[0] = par_in[K-1]`).
- R5: When `par_in` equals the true interleaved parity of `a_in`, `err_q` is 0 on the following cycle.
- R6: When exactly one bit of `par_in` disagrees with the true interleaved parity of `a_in`, `err_q` is 1 on the following cycle (with `CHECK_EN` = 1).
- R7: While `rst` is high on a rising edge, `prod_q`, `par_q` and `err_q` are all cleared to 0 on that edge.
- R8: A zero operand with zero parity gives a zero product, zero predicted parity and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | M | Operand, bit i = coefficient of alpha^i |
| par_in | input | K | Interleaved parity of `a_in`, bit j covers indices congruent to j mod K |
| prod_q | output | M | Registered alpha times operand, reduced |
| par_q | output | K | Registered predicted interleaved parity of the product |
| err_q | output | 1 | Registered mismatch between predicted and regenerated product parity |

## Verification
The error-flag assertion only requires silence when the caller's parity vector matches the operand. The rotation assertions apply only to operands whose top bit is clear. Stimulus drives matching parity for every random operand, and corrupts exactly one parity bit only in directed cases, where the bench expects the flag. Random operands come from a fixed seed and cover both settings of the top bit. Directed values add zero, the lone top bit, all ones and the lowest bit.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

  localparam int MAX_W = 1024;

  // Parity of the polynomial coefficients that fall in interleaved segment seg.
  function automatic logic seg_poly_parity(logic [MAX_W-1:0] poly, int m, int k, int seg);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < m && (i % k) == seg) acc = acc ^ poly[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/alpha_shift.sv
module alpha_shift #(
  parameter int          M    = 16,
  parameter logic [M-1:0] POLY = 16'h002D
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);

  logic top;
  assign top = a[M-1];

  // Bit 0: only the constant polynomial term can feed it.
  generate
    if (POLY[0]) begin : g_b0_tap
      assign y[0] = top;
    end else begin : g_b0_none
      assign y[0] = 1'b0;
    end

    for (genvar i = 1; i < M; i++) begin : g_bit
      if (POLY[i]) begin : g_tap
        assign y[i] = a[i-1] ^ top;
      end else begin : g_wire
        assign y[i] = a[i-1];
      end
    end
  endgenerate

endmodule

// File: rtl/ilp_predict.sv
module ilp_predict #(
  parameter int           M    = 16,
  parameter int           K    = 4,
  parameter logic [M-1:0] POLY = 16'h002D
) (
  input  logic         top,
  input  logic [K-1:0] par_in,
  output logic [K-1:0] par_out
);

  import ilp_pkg::*;

  generate
    for (genvar j = 0; j < K; j++) begin : g_seg
      localparam logic PF = seg_poly_parity(MAX_W'(POLY), M, K, j);
      if (j == 0) begin : g_first
        // Source segment K-1 loses a[M-1], which wraps into reduction.
        if (PF) begin : g_plain
          assign par_out[0] = par_in[K-1];
        end else begin : g_flip
          assign par_out[0] = par_in[K-1] ^ top;
        end
      end else begin : g_rest
        if (PF) begin : g_flip
          assign par_out[j] = par_in[j-1] ^ top;
        end else begin : g_plain
          assign par_out[j] = par_in[j-1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ilp_regen.sv
module ilp_regen #(
  parameter int M = 16,
  parameter int K = 4
) (
  input  logic [M-1:0] v,
  output logic [K-1:0] par
);

  localparam int L = M / K;

  generate
    for (genvar j = 0; j < K; j++) begin : g_seg
      logic [L-1:0] members;
      for (genvar i = 0; i < L; i++) begin : g_pick
        assign members[i] = v[i*K + j];
      end
      assign par[j] = ^members;
    end
  endgenerate

endmodule

// File: rtl/alpha_mul_ilp.sv
module alpha_mul_ilp #(
  parameter int           M        = 16,
  parameter int           K        = 4,
  parameter logic [M-1:0] POLY     = 16'h002D,
  parameter bit           CHECK_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] a_in,
  input  logic [K-1:0] par_in,
  output logic [M-1:0] prod_q,
  output logic [K-1:0] par_q,
  output logic         err_q
);

  generate
    if (K < 1 || (M % K) != 0) begin : g_bad_split
      $error("alpha_mul_ilp: K must divide M");
    end
  endgenerate

  logic [M-1:0] prod_d;
  logic [K-1:0] pred_d;
  logic         err_d;

  alpha_shift #(.M(M), .POLY(POLY)) i_shift (
    .a (a_in),
    .y (prod_d)
  );

  ilp_predict #(.M(M), .K(K), .POLY(POLY)) i_pred (
    .top     (a_in[M-1]),
    .par_in  (par_in),
    .par_out (pred_d)
  );

  generate
    if (CHECK_EN) begin : g_check
      logic [K-1:0] regen;
      ilp_regen #(.M(M), .K(K)) i_regen (
        .v   (prod_d),
        .par (regen)
      );
      assign err_d = |(regen ^ pred_d);
    end else begin : g_nocheck
      assign err_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      par_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      prod_q <= prod_d;
      par_q  <= pred_d;
      err_q  <= err_d;
    end
  end

  // Assertion support: true parity of the operand, separate from the datapath.
  logic [K-1:0] in_true_par;
  ilp_regen #(.M(M), .K(K)) i_in_regen (
    .v   (a_in),
    .par (in_true_par)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (prod_q == '0 && par_q == '0 && !err_q)); // R7

  AST_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !a_in[M-1] |=> prod_q == {$past(a_in[M-2:0]), 1'b0}); // R4

  AST_PAR_ROTATE: assert property (@(posedge clk) disable iff (rst)
    !a_in[M-1] |=> par_q == {$past(par_in[K-2:0]), $past(par_in[K-1])}); // R4

  AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (par_in == in_true_par) |=> !err_q); // R5

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (a_in == '0 && par_in == '0) |=> (prod_q == '0 && par_q == '0 && !err_q)); // R8

endmodule

// File: tb/test_alpha_mul_ilp.sv
module test_alpha_mul_ilp;

  localparam int           M    = 16;
  localparam int           K    = 4;
  localparam logic [M-1:0] POLY = 16'h002D;

  logic         clk = 1'b0;
  logic         rst;
  logic [M-1:0] a_in;
  logic [K-1:0] par_in;
  logic [M-1:0] prod_q;
  logic [K-1:0] par_q;
  logic         err_q;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  alpha_mul_ilp #(.M(M), .K(K), .POLY(POLY), .CHECK_EN(1'b1)) i_alpha_mul_ilp (
    .clk(clk), .rst(rst), .a_in(a_in), .par_in(par_in),
    .prod_q(prod_q), .par_q(par_q), .err_q(err_q)
  );

  function automatic logic [M-1:0] ref_mul(logic [M-1:0] a);
    logic [M:0] w;
    w = {a, 1'b0};
    if (w[M]) w = w ^ {1'b1, POLY};
    return w[M-1:0];
  endfunction

  function automatic logic [K-1:0] ref_par(logic [M-1:0] v);
    logic [K-1:0] p;
    p = '0;
    for (int i = 0; i < M; i++) p[i % K] = p[i % K] ^ v[i];
    return p;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [M-1:0] a, logic [K-1:0] p);
    @(negedge clk);
    a_in   = a;
    par_in = p;
    @(negedge clk);
  endtask

  task automatic check_clean(logic [M-1:0] a);
    logic [M-1:0] e;
    logic [K-1:0] ep;
    apply(a, ref_par(a));
    e  = ref_mul(a);
    ep = ref_par(e);
    check("R1 product", 64'(prod_q), 64'(e));
    check("R2 parity j>=1", 64'(par_q[K-1:1]), 64'(ep[K-1:1]));
    check("R3 parity seg0", 64'(par_q[0]), 64'(ep[0]));
    check("R5 no error", 64'(err_q), 64'd0);
  endtask

  initial begin
    rst    = 1'b1;
    a_in   = 16'hBEEF;
    par_in = 4'hA;
    @(negedge clk);
    @(negedge clk);
    check("R7 reset prod", 64'(prod_q), 64'd0);
    check("R7 reset par", 64'(par_q), 64'd0);
    check("R7 reset err", 64'(err_q), 64'd0);
    rst = 1'b0;

    // R8: zero operand
    apply('0, '0);
    check("R8 zero prod", 64'(prod_q), 64'd0);
    check("R8 zero par", 64'(par_q), 64'd0);
    check("R8 zero err", 64'(err_q), 64'd0);

    // R4: top bit clear, arbitrary (even inconsistent) parity rotates
    apply(16'h1234, 4'b1001);
    check("R4 shift", 64'(prod_q), 64'(16'h2468));
    check("R4 rotate", 64'(par_q), 64'(4'b0011));

    // Directed corners
    check_clean(16'h8000);
    check_clean(16'hFFFF);
    check_clean(16'h0001);
    check_clean(16'h8421);

    // R6: single corrupted parity bit in each position
    for (int j = 0; j < K; j++) begin
      apply(16'hC35A, ref_par(16'hC35A) ^ (K'(1) << j));
      check("R6 flag", 64'(err_q), 64'd1);
    end

    // Random sweep
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      logic [M-1:0] r;
      r = M'($urandom());
      check_clean(r);
    end

    // R7: reset mid-run clears outputs
    @(negedge clk);
    a_in = 16'hFFFF; par_in = ref_par(16'hFFFF); rst = 1'b1;
    @(negedge clk);
    check("R7 midrun prod", 64'(prod_q), 64'd0);
    check("R7 midrun par", 64'(par_q), 64'd0);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule